// File: doc/BRIEF.md
# Sequential Signed Multiply/Divide Unit

This block performs signed multiplication and division on a pair of 16-bit accumulator words, called A and B, and on one 16-bit memory operand that arrives on an input port. A multiply forms the full 32-bit signed product of A and the operand. The high word of the product goes to B and the low word goes to A. A divide treats B:A as a 32-bit two's-complement dividend and the operand as a 16-bit divisor. The quotient goes to A, the remainder goes to B, and an overflow flag records whether the result is valid.

The unit runs one radix-2 step per clock. Multiply uses shift-and-add. Divide uses restoring shift-and-subtract. Both work on magnitudes, and a separate finishing cycle applies the signs. The caller presents bits 15..4 of the instruction word with the A, B and operand values and pulses `start`. The unit samples everything on that edge. It keeps `busy` high while it computes and pulses `done` for one cycle when `aOut`, `bOut` and `ovf` hold the new result. Between operations the result outputs keep their last values.

Top module: `muldiv_unit`

## Requirements
- R1: An operation starts only when `start` is high and `busy` is low. Multiply is selected when `opHi[11:4]` = 8'o200 and `opHi[3:0]` = 4'o10. Divide is selected when `opHi[11:4]` = 8'o201, whatever `opHi[3:0]` holds. Any other code is ignored: `busy` and `done` stay low and `aOut`, `bOut` and `ovf` do not change.
- R2: Multiply puts the signed product of `aIn` and `opnd` in `bOut` (high word) and `aOut` (low word), and clears `ovf`. This includes operands of -32768.
- R3: Divide forms the magnitudes of the 32-bit dividend {`bIn`,`aIn`} and of the divisor. If the high 16 bits of the dividend magnitude are greater than or equal to the divisor magnitude, `ovf` is set and `aOut`/`bOut` take the `aIn`/`bIn` values captured at start. A zero divisor always takes this path.
- R4: Otherwise the quotient magnitude is the dividend magnitude divided by the divisor magnitude, truncated. The quotient is negated only when it is nonzero and the dividend and divisor signs differ. The remainder carries the dividend's sign and goes to `bOut`. The quotient goes to `aOut`.
- R5: On that path, `ovf` is set when the quotient is nonzero and its sign bit after signing differs from the XOR of the operand signs. `aOut`/`bOut` still receive the quotient and remainder. Otherwise `ovf` is cleared.
- R6: `busy` is high from the edge that accepts `start` until the result is written. `done` is high for exactly one cycle, when `busy` falls. Counting edges after the accepting edge, `done` appears after W+1 edges for a multiply or a completed divide, and after 1 edge for an R3 overflow.
- R7: Operands are sampled only on the accepting edge. Later changes to `aIn`, `bIn`, `opnd` and `opHi`, including a further `start` while `busy` is high, do not affect the result, and no second `done` follows.
- R8: After reset, `aOut`, `bOut`, `ovf`, `busy` and `done` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to begin the operation selected by `opHi` |
| opHi | input | 12 | Instruction bits 15..4: group code in [11:4], subfield in [3:0] |
| aIn | input | W | Current A word (multiplicand, or low dividend word) |
| bIn | input | W | Current B word (high dividend word) |
| opnd | input | W | Memory operand (multiplier or divisor) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse: results valid |
| aOut | output | W | New A: product low word or quotient |
| bOut | output | W | New B: product high word or remainder |
| ovf | output | 1 | Overflow flag |

## Verification
The hardest case to reach is the late overflow. The magnitude division must succeed, so the high dividend half is below the divisor, but the signed quotient must still fail to fit. This happens only for a quotient magnitude of exactly 32768, where the result is valid when the signs differ and overflows when they agree. The stimulus reaches it directly with dividends of plus and minus 32768 against divisors of plus and minus one. It also sweeps a cross product of edge words for B, A and the divisor, which lands on both overflow paths, zero divisors and zero quotients with negative signs. Random dividends with a randomly shortened high word then push most random divides past the pre-check.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

  // Instruction group and subfield codes that select an operation.
  localparam logic [7:0] GRP_MUL = 8'o200;
  localparam logic [3:0] SUB_MUL = 4'o10;
  localparam logic [7:0] GRP_DIV = 8'o201;

  // Strobes from control to datapath.
  typedef struct packed {
    logic load;    // capture operands, set up magnitudes
    logic step;    // one radix-2 iteration
    logic finish;  // apply signs and write results
    logic divSel;  // operation kind at load: 1 = divide
  } mdStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } mdState_t;

endpackage

// File: rtl/muldiv_ctrl.sv
module muldiv_ctrl
  import muldiv_pkg::*;
#(
  parameter int W = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [11:0] opHi,
  input  logic       preOvf,
  output mdStrobe_t  ctl,
  output logic       busy,
  output logic       done
);

  localparam int CW = $clog2(W) + 1;
  localparam logic [CW-1:0] LAST_STEP = CW'(W - 1);

  mdState_t state, stateNxt;
  logic [CW-1:0] stepCnt;
  logic doneQ;
  logic isMul, isDiv, accept;

  always_comb begin
    isMul  = (opHi[11:4] == GRP_MUL) && (opHi[3:0] == SUB_MUL);
    isDiv  = (opHi[11:4] == GRP_DIV);
    accept = start && (state == ST_IDLE) && (isMul || isDiv);
  end

  always_comb begin
    ctl.load   = accept;
    ctl.divSel = isDiv;
    ctl.step   = (state == ST_RUN);
    ctl.finish = (state == ST_FIN);
  end

  always_comb begin
    stateNxt = state;
    unique case (state)
      ST_IDLE: if (accept) stateNxt = (isDiv && preOvf) ? ST_FIN : ST_RUN;
      ST_RUN:  if (stepCnt == LAST_STEP) stateNxt = ST_FIN;
      ST_FIN:  stateNxt = ST_IDLE;
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      stepCnt <= '0;
      doneQ   <= 1'b0;
    end else begin
      state <= stateNxt;
      doneQ <= (state == ST_FIN);
      if (accept) stepCnt <= '0;
      else if (state == ST_RUN) stepCnt <= stepCnt + 1'b1;
    end
  end

  assign busy = (state != ST_IDLE);
  assign done = doneQ;

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R6
  busy_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);

  // R6
  step_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN) |-> (stepCnt <= LAST_STEP));

  // R7
  busy_origin_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(start));

endmodule

// File: rtl/muldiv_dp.sv
module muldiv_dp
  import muldiv_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  mdStrobe_t    ctl,
  input  logic [W-1:0] aIn,
  input  logic [W-1:0] bIn,
  input  logic [W-1:0] opnd,
  output logic         preOvf,
  output logic [W-1:0] aOut,
  output logic [W-1:0] bOut,
  output logic         ovf
);

  localparam int DW = 2 * W;

  // Shared work register: multiply = {carry, partial, multiplier},
  // divide = {unused, remainder, quotient-in-progress}.
  logic [DW:0]   work;
  logic [W-1:0]  mag;
  logic          divR, negRes, remNeg, preOvfR;
  logic [W-1:0]  aSave, bSave;

  // Input magnitudes, used at load.
  logic          aNeg, dNeg, vNeg;
  logic [W-1:0]  aMag, vMag;
  logic [DW-1:0] dMag;

  always_comb begin
    aNeg   = aIn[W-1];
    dNeg   = bIn[W-1];
    vNeg   = opnd[W-1];
    aMag   = aNeg ? (~aIn + 1'b1) : aIn;
    vMag   = vNeg ? (~opnd + 1'b1) : opnd;
    dMag   = dNeg ? (~{bIn, aIn} + 1'b1) : {bIn, aIn};
    preOvf = (dMag[DW-1:W] >= vMag);
  end

  // One iteration of each algorithm.
  logic [W:0]    mulSum;
  logic [W:0]    trial, diff;
  logic          fits;
  logic [W-1:0]  newRem;

  always_comb begin
    mulSum = work[DW:W] + (work[0] ? {1'b0, mag} : {(W+1){1'b0}});
    trial  = work[DW-1:W-1];
    diff   = trial - {1'b0, mag};
    fits   = (trial >= {1'b0, mag});
    newRem = fits ? diff[W-1:0] : trial[W-1:0];
  end

  // Sign fix-up for the finishing cycle.
  logic [DW-1:0] prodVal;
  logic [W-1:0]  qMag, rMag, qVal, rVal;
  logic          qNz, postOvf;

  always_comb begin
    prodVal = negRes ? (~work[DW-1:0] + 1'b1) : work[DW-1:0];
    qMag    = work[W-1:0];
    rMag    = work[DW-1:W];
    qNz     = |qMag;
    qVal    = (qNz && negRes) ? (~qMag + 1'b1) : qMag;
    postOvf = qNz && (qVal[W-1] != negRes);
    rVal    = remNeg ? (~rMag + 1'b1) : rMag;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      work    <= '0;
      mag     <= '0;
      divR    <= 1'b0;
      negRes  <= 1'b0;
      remNeg  <= 1'b0;
      preOvfR <= 1'b0;
      aSave   <= '0;
      bSave   <= '0;
      aOut    <= '0;
      bOut    <= '0;
      ovf     <= 1'b0;
    end else begin
      if (ctl.load) begin
        aSave   <= aIn;
        bSave   <= bIn;
        divR    <= ctl.divSel;
        preOvfR <= preOvf;
        remNeg  <= dNeg;
        if (ctl.divSel) begin
          work   <= {1'b0, dMag};
          mag    <= vMag;
          negRes <= dNeg ^ vNeg;
        end else begin
          work   <= {{(W+1){1'b0}}, vMag};
          mag    <= aMag;
          negRes <= aNeg ^ vNeg;
        end
      end else if (ctl.step) begin
        if (divR) work <= {1'b0, newRem, work[W-2:0], fits};
        else      work <= {1'b0, mulSum, work[W-1:1]};
      end

      if (ctl.finish) begin
        if (!divR) begin
          aOut <= prodVal[W-1:0];
          bOut <= prodVal[DW-1:W];
          ovf  <= 1'b0;
        end else if (preOvfR) begin
          aOut <= aSave;
          bOut <= bSave;
          ovf  <= 1'b1;
        end else begin
          aOut <= qVal;
          bOut <= rVal;
          ovf  <= postOvf;
        end
      end
    end
  end

  // R2
  mul_ovf_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.finish && !divR) |=> !ovf);

  // R3
  pre_ovf_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.finish && divR && preOvfR) |=> (ovf && aOut == $past(aSave) && bOut == $past(bSave)));

  // R4
  rem_sign_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.finish && divR && !preOvfR) |=> (bOut == '0 || bOut[W-1] == $past(remNeg)));

  // R5
  quot_ovf_nz_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.finish && divR && !preOvfR) |=> (!ovf || aOut != '0));

endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
  import muldiv_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic [11:0]  opHi,
  input  logic [W-1:0] aIn,
  input  logic [W-1:0] bIn,
  input  logic [W-1:0] opnd,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] aOut,
  output logic [W-1:0] bOut,
  output logic         ovf
);

  mdStrobe_t ctl;
  logic      preOvf;

  muldiv_ctrl #(.W(W)) uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .opHi   (opHi),
    .preOvf (preOvf),
    .ctl    (ctl),
    .busy   (busy),
    .done   (done)
  );

  muldiv_dp #(.W(W)) uDp (
    .clk    (clk),
    .rstN   (rstN),
    .ctl    (ctl),
    .aIn    (aIn),
    .bIn    (bIn),
    .opnd   (opnd),
    .preOvf (preOvf),
    .aOut   (aOut),
    .bOut   (bOut),
    .ovf    (ovf)
  );

endmodule

// File: tb/sim_muldiv_unit.sv
`timescale 1ns/1ps
module sim_muldiv_unit;

  localparam int W = 16;
  localparam logic [11:0] C_MUL  = 12'h808;
  localparam logic [11:0] C_DIV  = 12'h810;
  localparam logic [11:0] C_DIVX = 12'h81F;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [11:0] opHi = '0;
  logic [W-1:0] aIn = '0, bIn = '0, opnd = '0;
  logic busy, done, ovf;
  logic [W-1:0] aOut, bOut;

  int nChk = 0;
  int nBad = 0;

  always #2 clk = ~clk;

  muldiv_unit #(.W(W)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .opHi(opHi),
    .aIn(aIn), .bIn(bIn), .opnd(opnd),
    .busy(busy), .done(done), .aOut(aOut), .bOut(bOut), .ovf(ovf)
  );

  task automatic check(input string req, input string what, input longint act, input longint exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
  endtask

  // Expected results from the requirements.
  task automatic model(input logic [11:0] code, input logic [15:0] a, b, v,
                       output logic [15:0] eA, eB, output logic eO, output int eL,
                       output string tag);
    longint p, dv, vv, md, mv, qm, rm, q, r;
    bit qs;
    if (code[11:4] == 8'o200) begin
      p  = longint'($signed(a)) * longint'($signed(v));
      eA = p[15:0]; eB = p[31:16]; eO = 1'b0; eL = W + 1; tag = "R2";
    end else begin
      dv = longint'($signed({b, a}));
      vv = longint'($signed(v));
      md = (dv < 0) ? -dv : dv;
      mv = (vv < 0) ? -vv : vv;
      if ((md >> 16) >= mv) begin
        eA = a; eB = b; eO = 1'b1; eL = 1; tag = "R3";
      end else begin
        qm = md / mv; rm = md % mv;
        qs = (dv < 0) != (vv < 0);
        q  = qs ? -qm : qm;
        eA = q[15:0];
        eO = (qm != 0) && (eA[15] != qs);
        r  = (dv < 0) ? -rm : rm;
        eB = r[15:0];
        eL = W + 1;
        tag = eO ? "R5" : "R4";
      end
    end
  endtask

  task automatic runOp(input logic [11:0] code, input logic [15:0] a, b, v, input bit poke);
    logic [15:0] eA, eB; logic eO; int eL; string tag;
    int n; bit seen;
    model(code, a, b, v, eA, eB, eO, eL, tag);
    @(negedge clk);
    opHi = code; aIn = a; bIn = b; opnd = v; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R7: scramble inputs after the accepting edge
    aIn = ~a; bIn = b ^ 16'h5A5A; opnd = v + 16'h0101; opHi = C_MUL;
    n = 0; seen = 1'b0;
    for (int i = 0; i < 40 && !seen; i++) begin
      if (poke && i == 2) begin start = 1'b1; opHi = C_DIV; end
      if (poke && i == 3) start = 1'b0;
      @(posedge clk);
      n++;
      @(negedge clk);
      if (done) seen = 1'b1;
    end
    start = 1'b0;
    check("R6", "done seen", seen, 1);
    check("R6", "latency", n, eL);
    check(tag, "aOut", aOut, eA);
    check(tag, "bOut", bOut, eB);
    check(tag, "ovf", ovf, eO);
    @(negedge clk);
    check("R6", "done one cycle", done, 0);
    check("R6", "busy low after done", busy, 0);
    if (poke) begin
      seen = 1'b0;
      for (int i = 0; i < 30; i++) begin
        @(negedge clk);
        if (done || busy) seen = 1'b1;
      end
      check("R7", "no second operation", seen, 0);
      check("R7", "aOut held", aOut, eA);
      check("R7", "bOut held", bOut, eB);
    end
  endtask

  task automatic ignoreOp(input logic [11:0] code);
    logic [15:0] pa, pb; logic po; bit act;
    pa = aOut; pb = bOut; po = ovf; act = 1'b0;
    @(negedge clk);
    opHi = code; aIn = 16'h1357; bIn = 16'h0001; opnd = 16'h0777; start = 1'b1;
    @(negedge clk);
    if (busy) act = 1'b1;
    start = 1'b0;
    for (int i = 0; i < 25; i++) begin
      @(negedge clk);
      if (busy || done) act = 1'b1;
    end
    check("R1", "ignored code activity", act, 0);
    check("R1", "aOut unchanged", aOut, pa);
    check("R1", "bOut unchanged", bOut, pb);
    check("R1", "ovf unchanged", ovf, po);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  localparam int NE = 10;
  logic [15:0] edges [NE] = '{16'h8000, 16'h8001, 16'hFFFF, 16'h0000, 16'h0001,
                              16'h0002, 16'h7FFF, 16'h7FFE, 16'h1234, 16'hEDCB};

  initial begin
    repeat (3) @(negedge clk);
    // R8: reset values
    check("R8", "aOut", aOut, 0);
    check("R8", "bOut", bOut, 0);
    check("R8", "ovf", ovf, 0);
    check("R8", "busy", busy, 0);
    check("R8", "done", done, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R5 corner: quotient magnitude exactly 32768
    runOp(C_DIV, 16'h8000, 16'h0000, 16'h0001, 1'b0);
    runOp(C_DIV, 16'h8000, 16'h0000, 16'hFFFF, 1'b0);
    runOp(C_DIV, 16'h8000, 16'hFFFF, 16'h0001, 1'b0);
    runOp(C_DIV, 16'h8000, 16'hFFFF, 16'hFFFF, 1'b0);
    // R3: zero divisor
    runOp(C_DIV, 16'h0005, 16'h0000, 16'h0000, 1'b0);
    // R1: divide with nonzero subfield
    runOp(C_DIVX, 16'h0064, 16'h0000, 16'hFFF9, 1'b0);
    // R2: extreme product
    runOp(C_MUL, 16'h8000, 16'h0000, 16'h8000, 1'b0);
    // R1: unsupported codes
    ignoreOp(12'h801);
    ignoreOp(12'h828);
    ignoreOp(12'h808 ^ 12'h200);
    ignoreOp(12'h880);
    // R7: start while busy
    runOp(C_MUL, 16'h0123, 16'h0000, 16'hFF00, 1'b1);
    runOp(C_DIV, 16'h4000, 16'h0003, 16'h0010, 1'b1);

    // Edge sweep: multiply
    for (int i = 0; i < NE; i++)
      for (int j = 0; j < NE; j++)
        runOp(C_MUL, edges[i], 16'h0000, edges[j], 1'b0);
    // Edge sweep: divide
    for (int i = 0; i < NE; i++)
      for (int j = 0; j < NE; j++)
        for (int k = 0; k < NE; k++)
          runOp(C_DIV, edges[j], edges[i], edges[k], 1'b0);
    // Random
    for (int i = 0; i < 1200; i++)
      runOp(C_MUL, 16'($urandom()), 16'($urandom()), 16'($urandom()), 1'b0);
    for (int i = 0; i < 1200; i++) begin
      logic [15:0] hb;
      hb = 16'($urandom()) >> ($urandom() % 17);
      if ($urandom() % 2 == 1) hb = ~hb;
      runOp(C_DIV, 16'($urandom()), hb, 16'($urandom()), 1'b0);
    end

    summary();
    $finish;
  end

endmodule